// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps edges on an external pin for a small 8-bit controller. A 16-bit free-running count advances once every four clock cycles through a fixed divider. The pin is asynchronous, so it is resynchronized first. A control input picks whether a rising or a falling level change is the event of interest. When that event is seen, the current count plus one is stored in a 16-bit capture register. The extra one covers the delay of the synchronizer.

Software reads the stored value as two bytes over an 8-bit read port, upper byte first. An upper-byte read freezes the capture register until the lower byte is read, so the two halves always belong to the same event. A capture flag marks each accepted event and drives an interrupt request when interrupts are enabled. The flag is cleared by a two-step sequence: a status read that sees the flag set, followed by a lower-byte read.

Top module: `icap_unit`

## Requirements
- R1: After a synchronous reset the count is 0xFFFC and the divider is zero. After the k-th clock edge following reset release, the count is 0xFFFC + floor(k/4), wrapping modulo 2^16.
- R2: When `rise_sel_i` is 1, only a low-to-high pin change captures. When it is 0, only a high-to-low change captures. A change in the other direction leaves the capture register and the flag untouched.
- R3: Suppose a pin change is first sampled at clock edge S. The capture is written at edge S+2 and holds the count present after edge S+1, plus one.
- R4: The read map uses `addr_i`. Address 0 is status, with bit 0 holding the flag and the other bits reading 0. Address 1 is the upper capture byte (bits 15:8). Address 2 is the lower byte (bits 7:0). Address 3 reads 0. `rdata_o` follows `addr_i` in the same cycle.
- R5: A read of address 1 with `rd_i` high blocks captures, starting in the same cycle, until a read of address 2. An event that arrives while captures are blocked is dropped: it sets no flag and changes no capture byte.
- R6: Every accepted capture sets the flag. The flag clears only on a read of address 2 that follows a status read which returned the flag as 1. A lower-byte read with no such status read leaves the flag set.
- R7: `irq_o` is 1 exactly when the flag is 1 and `irq_en_i` is 1.
- R8: Reset clears the flag and the read block. Reset leaves the capture register contents unchanged.
- R9: If a capture and a flag-clearing lower-byte read fall in the same cycle, the flag stays set and the new value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pin_i | input | 1 | Asynchronous capture pin |
| rise_sel_i | input | 1 | 1 selects rising events, 0 selects falling events |
| irq_en_i | input | 1 | Interrupt enable |
| rd_i | input | 1 | Read strobe, one cycle per access |
| addr_i | input | 2 | Register select |
| rdata_o | output | 8 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench changes the pin just after a falling clock edge, at a known clock-edge count P. The pin is first sampled at edge P+1, and the capture lands at edge P+3 holding 0xFFFC + floor((P+2)/4) + 1. Flag and capture reads are therefore scheduled at least four cycles after each pin change. Read data is combinational, so each scoreboard item is compared while the strobe is high, a quarter period before the edge that carries the read's side effects. The same-cycle case of R9 is produced by raising the strobe so that it straddles edge P+3; that read must still return the older lower byte.

// File: rtl/icap_pkg.sv
`timescale 1ns/1ps
package icap_pkg;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_CAP_HI = 2'd1,
        SEL_CAP_LO = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic rd_status;
        logic rd_hi;
        logic rd_lo;
    } bus_rd_t;

    function automatic bus_rd_t decode_rd(input logic strobe, input logic [ADDR_W-1:0] addr);
        bus_rd_t r;
        r.rd_status = strobe && (reg_sel_e'(addr) == SEL_STATUS);
        r.rd_hi     = strobe && (reg_sel_e'(addr) == SEL_CAP_HI);
        r.rd_lo     = strobe && (reg_sel_e'(addr) == SEL_CAP_LO);
        return r;
    endfunction
endpackage

// File: rtl/icap_timebase.sv
`timescale 1ns/1ps
module icap_timebase #(
    parameter int CNT_W     = 16,
    parameter int PRESC_DIV = 4,
    parameter logic [CNT_W-1:0] CNT_RST = 16'hFFFC
) (
    input  logic             clk_i,
    input  logic             rst_i,
    output logic             tick_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
    localparam logic [PW-1:0] PLAST = PW'(PRESC_DIV - 1);

    logic [PW-1:0] presc_q;

    assign tick_o = (presc_q == PLAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            presc_q <= '0;
            cnt_o   <= CNT_RST;
        end else begin
            presc_q <= tick_o ? '0 : presc_q + PW'(1);
            if (tick_o) cnt_o <= cnt_o + CNT_W'(1);
        end
    end

    // R1: the count moves by exactly one on a divider tick
    p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));
    // R1: the count is frozen between ticks
    p_cnt_idle_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_o |=> $stable(cnt_o));
endmodule

// File: rtl/icap_edge.sv
`timescale 1ns/1ps
module icap_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_i,
    input  logic rise_sel_i,
    output logic event_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk_i) begin
                if (rst_i) sync_q <= '0;
                else       sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            end
        end else begin : g_single
            always_ff @(posedge clk_i) begin
                if (rst_i) sync_q <= '0;
                else       sync_q <= pin_i;
            end
        end
    endgenerate

    assign cur = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= cur;
    end

    assign event_o = rise_sel_i ? (cur & ~prev_q) : (~cur & prev_q);
endmodule

// File: rtl/icap_hold.sv
`timescale 1ns/1ps
module icap_hold
    import icap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             event_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  bus_rd_t          rd_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             flag_o
);
    logic blocked_q;
    logic armed_q;
    logic cap_we;

    assign cap_we = event_i && !blocked_q && !rd_i.rd_hi;

    // Capture storage is deliberately outside the reset domain
    always_ff @(posedge clk_i) begin
        if (cap_we) cap_o <= cnt_i + CNT_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            blocked_q <= 1'b0;
            armed_q   <= 1'b0;
            flag_o    <= 1'b0;
        end else begin
            if (rd_i.rd_hi)      blocked_q <= 1'b1;
            else if (rd_i.rd_lo) blocked_q <= 1'b0;

            if (rd_i.rd_lo)                     armed_q <= 1'b0;
            else if (rd_i.rd_status && flag_o)  armed_q <= 1'b1;

            if (cap_we)                         flag_o <= 1'b1;
            else if (rd_i.rd_lo && armed_q)     flag_o <= 1'b0;
        end
    end

    // R5: while blocked and the low byte is not read, the capture value holds
    p_block_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (blocked_q && !rd_i.rd_lo) |=> $stable(cap_o));
    // R6: an accepted event leaves the flag set
    p_flag_set_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        cap_we |=> flag_o);
    // R6: the flag only falls after an armed low-byte read
    p_flag_fall_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(flag_o) |-> $past(rd_i.rd_lo && armed_q));
    // R3: the stored value is one past the count seen at the event
    p_capture_plus1_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        cap_we |=> (cap_o == $past(cnt_i) + CNT_W'(1)));
endmodule

// File: rtl/icap_unit.sv
`timescale 1ns/1ps
module icap_unit
    import icap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PRESC_DIV   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              pin_i,
    input  logic              rise_sel_i,
    input  logic              irq_en_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              irq_o
);
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             evt;
    logic [CNT_W-1:0] cap;
    logic             flag;
    bus_rd_t          rd_dec;

    assign rd_dec = decode_rd(rd_i, addr_i);

    icap_timebase #(.CNT_W(CNT_W), .PRESC_DIV(PRESC_DIV), .CNT_RST(CNT_W'(16'hFFFC))) u_tb (
        .clk_i (clk_i), .rst_i (rst_i), .tick_o (tick), .cnt_o (cnt)
    );

    icap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk_i (clk_i), .rst_i (rst_i), .pin_i (pin_i),
        .rise_sel_i (rise_sel_i), .event_o (evt)
    );

    icap_hold #(.CNT_W(CNT_W)) u_hold (
        .clk_i (clk_i), .rst_i (rst_i), .event_i (evt), .cnt_i (cnt),
        .rd_i (rd_dec), .cap_o (cap), .flag_o (flag)
    );

    always_comb begin
        case (reg_sel_e'(addr_i))
            SEL_STATUS: rdata_o = {{(BUS_W-1){1'b0}}, flag};
            SEL_CAP_HI: rdata_o = cap[BUS_W +: BUS_W];
            SEL_CAP_LO: rdata_o = cap[0 +: BUS_W];
            default:    rdata_o = '0;
        endcase
    end

    assign irq_o = flag & irq_en_i;

    // R7: a request is raised only with the enable set
    p_irq_gate_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !irq_en_i |-> !irq_o);

    logic unused_tick;
    assign unused_tick = tick;
endmodule

// File: tb/icap_unit_tb_top.sv
`timescale 1ns/1ps
module icap_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin = 1'b0;
    logic       rise_sel = 1'b1;
    logic       irq_en = 1'b0;
    logic       rd = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int unsigned cyc = 0;
    bit done = 0;

    typedef struct {
        logic [1:0] a;
        logic [7:0] e;
        string      tag;
    } item_t;
    item_t sb_q[$];
    item_t cur_it;

    always #2.5 clk = ~clk;

    icap_unit dut_i (
        .clk_i(clk), .rst_i(rst), .pin_i(pin), .rise_sel_i(rise_sel),
        .irq_en_i(irq_en), .rd_i(rd), .addr_i(addr), .rdata_o(rdata), .irq_o(irq)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // monitor: compares read data while the strobe is high, between edges
    always begin
        @(negedge clk);
        #1.25;
        if (rd) begin
            checks++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard empty: actual %h expected none", rdata);
            end else begin
                cur_it = sb_q.pop_front();
                if (rdata !== cur_it.e) begin
                    fails++;
                    $display("FAIL %s addr %0d: actual %h expected %h",
                             cur_it.tag, cur_it.a, rdata, cur_it.e);
                end
            end
        end
    end

    task automatic bus_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a;
        rd   = 1'b1;
        sb_q.push_back('{a, e, tag});
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic read_cap(input logic [15:0] v, input string tag);
        bus_rd(2'd1, v[15:8], tag);
        bus_rd(2'd2, v[7:0], tag);
    endtask

    // change the pin after a falling edge; value a capture would hold
    task automatic pin_to(input logic v, output logic [15:0] expv);
        @(negedge clk);
        pin  = v;
        expv = 16'(32'hFFFC + ((cyc + 2) >> 2) + 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] c1, c2, c3, c4, c5, junk;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R8/R4: flag clear after reset
        bus_rd(2'd0, 8'h00, "R8 status after reset");
        bus_rd(2'd3, 8'h00, "R4 spare address");
        irq_en = 1'b1;
        @(negedge clk) #1 chk_bit(irq, 1'b0, "R7 no request after reset");

        // R1/R3: early capture near the wrap, rising edge
        pin_to(1'b1, c1);
        bus_rd(2'd0, 8'h01, "R6 flag after capture");
        #1 chk_bit(irq, 1'b1, "R7 request with flag and enable");
        read_cap(c1, "R1 R3 first capture");
        bus_rd(2'd0, 8'h00, "R6 flag cleared by status then low read");

        // R2: falling change ignored while rising is selected
        pin_to(1'b0, junk);
        bus_rd(2'd0, 8'h00, "R2 opposite edge sets no flag");
        read_cap(c1, "R2 opposite edge keeps value");

        // R2: falling selected
        rise_sel = 1'b0;
        pin_to(1'b1, junk);
        bus_rd(2'd0, 8'h00, "R2 rising ignored when falling selected");
        pin_to(1'b0, c2);
        read_cap(c2, "R2 R3 falling capture");
        bus_rd(2'd0, 8'h01, "R6 low read without status keeps flag");
        bus_rd(2'd2, c2[7:0], "R6 armed low read");
        bus_rd(2'd0, 8'h00, "R6 flag cleared");

        // R5: upper read blocks
        rise_sel = 1'b1;
        bus_rd(2'd1, c2[15:8], "R5 upper read");
        pin_to(1'b1, junk);
        bus_rd(2'd0, 8'h00, "R5 blocked event sets no flag");
        bus_rd(2'd2, c2[7:0], "R5 blocked event keeps value");
        pin_to(1'b0, junk);
        pin_to(1'b1, c3);
        irq_en = 1'b0;
        @(negedge clk) #1 chk_bit(irq, 1'b0, "R7 no request when disabled");
        bus_rd(2'd0, 8'h01, "R5 capture allowed after low read");
        read_cap(c3, "R3 R5 capture after unblock");

        // R8: reset keeps capture contents
        pin_to(1'b0, junk);
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        bus_rd(2'd0, 8'h00, "R8 flag cleared by reset");
        read_cap(c3, "R8 capture survives reset");

        // R9: capture in the same cycle as a clearing low read
        pin_to(1'b1, c4);
        read_cap(c4, "R1 R3 capture after second reset");
        bus_rd(2'd0, 8'h01, "R9 arming status read");
        rise_sel = 1'b0;
        @(negedge clk);
        pin = 1'b0;
        c5 = 16'(32'hFFFC + ((cyc + 2) >> 2) + 1);
        @(negedge clk);
        bus_rd(2'd2, c4[7:0], "R9 colliding low read returns old byte");
        repeat (3) @(negedge clk);
        bus_rd(2'd0, 8'h01, "R9 flag kept on collision");
        read_cap(c5, "R9 new value stored on collision");

        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule